// File: doc/BRIEF.md
# Store Queue with Store-to-Load Forwarding

This block keeps the in-flight stores of an out-of-order core in a circular queue and answers load lookups against them. Each store gets a slot at allocation, later receives its address, size and data, is marked done once its writeback to memory has finished, and leaves the queue from the oldest end at retirement. A load presents its address, its size and the queue tail it saw when it was allocated. The block then searches only the stores older than that load, starting with the youngest of them.

A load whose bytes lie entirely inside one such store gets the shifted store data one cycle later. A load that only partly overlaps a store still waiting for writeback is sent back for replay. The block then holds a stall record naming the oldest such load and the store it waits on. A load that matches nothing goes out on a memory read lane. Reads are limited to a fixed number per cycle, and a read that memory refuses is kept as a blocked-load record. Several lookup lanes are served in the same cycle.

Top module: `stq_fwd`

## Requirements
- R1: After reset the queue is empty, the allocation index is 0 and `sq_full` is 0. `sq_full` is 1 once occupancy reaches DEPTH-1. An allocation request while full is ignored, and the allocation index does not advance.
- R2: A lookup searches only entries from (load tail − 1) back to the oldest entry, modulo DEPTH. Entries that were allocated but never written are skipped, and a lookup with nothing matching issues a memory read.
- R3: When the load range [a, a+L) lies inside a store range [s, s+S), `fwd_valid` for that lane is 1 exactly one cycle after the lookup. It carries the load-queue index, and the data is (store data >> 8·(a AND (S−1))) masked to L bytes. The size code c on any size port means 2^c bytes (0=1, 1=2, 2=4, 3=8).
- R4: When several searched stores match, the youngest one decides the result.
- R5: A store that only partly overlaps the load, but is already marked done, is passed over, and the search continues to older stores.
- R6: A partial overlap with a store not yet done raises `replay` in the same cycle, with no memory read and no forward. The stall record (`stalled`, the store's sequence tag, the load-queue index) is taken only if no stall is recorded or this load is older than the recorded one. It clears when that store is marked done.
- R7: At most MEM_PORTS memory reads issue per cycle, with lower lane numbers taking priority. A lane that needs a read but finds no port left gets `replay`.
- R8: An issued read with `mem_rd_ready` low sets `blocked` and records the load's sequence tag, unless an older load is already recorded. `blocked_clear` clears the record.
- R9: An uncacheable load that is not at the load-queue head, or not ready to commit, gets `fault` and `replay` and issues no read. When both conditions hold it is looked up normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store slot at the tail |
| alloc_seq | input | SEQ_W | Sequence tag of the allocated store |
| alloc_idx | output | IDX_W | Slot the next allocation takes |
| sq_full | output | 1 | Occupancy reached DEPTH-1 |
| wr_valid | input | 1 | Write address/size/data into a slot |
| wr_idx | input | IDX_W | Slot written |
| wr_addr | input | ADDR_W | Store byte address |
| wr_size | input | 2 | Store size code |
| wr_data | input | DATA_W | Store data, byte 0 in bits 7:0 |
| done_valid | input | 1 | Mark a slot's writeback finished |
| done_idx | input | IDX_W | Slot marked done |
| retire_valid | input | 1 | Free the oldest slot |
| ld_valid | input | LANES | Lookup request per lane |
| ld_addr | input | LANES*ADDR_W | Load address per lane |
| ld_size | input | LANES*2 | Load size code per lane |
| ld_sq_tail | input | LANES*IDX_W | Store tail seen at load allocation |
| ld_seq | input | LANES*SEQ_W | Load sequence tag |
| ld_lq_idx | input | LANES*LQ_W | Load-queue index |
| ld_uncache | input | LANES | Load is uncacheable |
| ld_at_head | input | LANES | Load is at load-queue head |
| ld_commit_ok | input | LANES | Load is ready to commit |
| fwd_valid | output | LANES | Forwarded result valid |
| fwd_data | output | LANES*DATA_W | Forwarded data |
| fwd_lq_idx | output | LANES*LQ_W | Load-queue index of forwarded load |
| replay | output | LANES | Load must be rescheduled |
| fault | output | LANES | Uncacheable access rejected |
| mem_rd_valid | output | LANES | Memory read issued |
| mem_rd_addr | output | LANES*ADDR_W | Read address |
| mem_rd_size | output | LANES*2 | Read size code |
| mem_rd_ready | input | LANES | Memory accepts the read |
| stalled | output | 1 | Stall record present |
| stall_st_seq | output | SEQ_W | Store the stalled load waits on |
| stall_lq_idx | output | LQ_W | Oldest stalled load's index |
| blocked | output | 1 | Blocked-load record present |
| blocked_seq | output | SEQ_W | Sequence tag of blocked load |
| blocked_clear | input | 1 | Clear the blocked record |

## Verification
A head or tail pointer that is off by one moves the search window. The next lookup then picks an older or unwritten store, which shows up as wrong forwarded data one cycle later or as a memory read where a forward was due. A lost done bit keeps `replay` asserted for a load that should have been forwarded, and it leaves `stalled` set after the store finished. A wrong stall or blocked comparison shows on the record outputs in the cycle after the second, competing load.

// File: rtl/stq_pkg.sv
package stq_pkg;
   typedef enum logic [1:0] {SZ_1B = 2'd0, SZ_2B = 2'd1, SZ_4B = 2'd2, SZ_8B = 2'd3} size_code_e;

   function automatic int unsigned size_bytes(input logic [1:0] code);
      return 32'd1 << code;
   endfunction
endpackage

// File: rtl/stq_probe.sv
module stq_probe
   import stq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 64,
   parameter int IDX_W  = 3
) (
   input  logic [IDX_W-1:0]        head,
   input  logic [IDX_W-1:0]        win,
   input  logic [ADDR_W-1:0]       ld_addr,
   input  logic [1:0]              ld_size,
   input  logic [DEPTH*ADDR_W-1:0] e_addr,
   input  logic [DEPTH*2-1:0]      e_size,
   input  logic [DEPTH-1:0]        e_wr,
   input  logic [DEPTH-1:0]        e_done,
   input  logic [DEPTH*DATA_W-1:0] e_data,
   output logic                    hit_full,
   output logic                    hit_part,
   output logic [IDX_W-1:0]        hit_idx,
   output logic [DATA_W-1:0]       fwd_data
);
   localparam int OFF_W = $clog2(DATA_W / 8);

   logic [IDX_W-1:0]  span, idx;
   logic [ADDR_W:0]   lo, hi, sa, se;
   logic              cov, ovl;
   logic [1:0]        st_sz;
   logic [OFF_W-1:0]  off;
   logic [DATA_W-1:0] shifted, ld_msk;

   // search window walk; later (younger) matches override older ones
   always_comb begin
      hit_full = 1'b0;
      hit_part = 1'b0;
      hit_idx  = '0;
      span     = win - head;
      lo       = {1'b0, ld_addr};
      hi       = lo + ((ADDR_W+1)'(1) << ld_size);
      idx      = '0;
      sa       = '0;
      se       = '0;
      cov      = 1'b0;
      ovl      = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         idx = head + IDX_W'(k);
         sa  = {1'b0, e_addr[idx*ADDR_W +: ADDR_W]};
         se  = sa + ((ADDR_W+1)'(1) << e_size[idx*2 +: 2]);
         cov = (lo >= sa) && (hi <= se);
         ovl = (lo < se) && (hi > sa);
         if ((IDX_W'(k) < span) && e_wr[idx] && (cov || (ovl && !e_done[idx]))) begin
            hit_full = cov;
            hit_part = !cov;
            hit_idx  = idx;
         end
      end
   end

   always_comb begin
      st_sz    = e_size[hit_idx*2 +: 2];
      off      = ld_addr[OFF_W-1:0] &
                 OFF_W'(((OFF_W+1)'(1) << st_sz) - (OFF_W+1)'(1));
      shifted  = e_data[hit_idx*DATA_W +: DATA_W] >> {off, 3'b000};
      ld_msk   = {DATA_W{1'b1}} >> (DATA_W - 8 * int'(size_bytes(ld_size)));
      fwd_data = shifted & ld_msk;
   end
endmodule

// File: rtl/stq_fwd.sv
module stq_fwd
   import stq_pkg::*;
#(
   parameter int DEPTH     = 8,
   parameter int LANES     = 2,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 64,
   parameter int SEQ_W     = 16,
   parameter int LQ_W      = 4,
   parameter int MEM_PORTS = 1,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    alloc_valid,
   input  logic [SEQ_W-1:0]        alloc_seq,
   output logic [IDX_W-1:0]        alloc_idx,
   output logic                    sq_full,
   input  logic                    wr_valid,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [1:0]              wr_size,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic                    done_valid,
   input  logic [IDX_W-1:0]        done_idx,
   input  logic                    retire_valid,
   input  logic [LANES-1:0]        ld_valid,
   input  logic [LANES*ADDR_W-1:0] ld_addr,
   input  logic [LANES*2-1:0]      ld_size,
   input  logic [LANES*IDX_W-1:0]  ld_sq_tail,
   input  logic [LANES*SEQ_W-1:0]  ld_seq,
   input  logic [LANES*LQ_W-1:0]   ld_lq_idx,
   input  logic [LANES-1:0]        ld_uncache,
   input  logic [LANES-1:0]        ld_at_head,
   input  logic [LANES-1:0]        ld_commit_ok,
   output logic [LANES-1:0]        fwd_valid,
   output logic [LANES*DATA_W-1:0] fwd_data,
   output logic [LANES*LQ_W-1:0]   fwd_lq_idx,
   output logic [LANES-1:0]        replay,
   output logic [LANES-1:0]        fault,
   output logic [LANES-1:0]        mem_rd_valid,
   output logic [LANES*ADDR_W-1:0] mem_rd_addr,
   output logic [LANES*2-1:0]      mem_rd_size,
   input  logic [LANES-1:0]        mem_rd_ready,
   output logic                    stalled,
   output logic [SEQ_W-1:0]        stall_st_seq,
   output logic [LQ_W-1:0]         stall_lq_idx,
   output logic                    blocked,
   output logic [SEQ_W-1:0]        blocked_seq,
   input  logic                    blocked_clear
);
   if ((1 << IDX_W) != DEPTH || DEPTH < 4) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (DATA_W != 64) begin : g_bad_data
      $error("DATA_W must be 64 to hold the widest size code");
   end
   if (MEM_PORTS < 1 || MEM_PORTS > LANES) begin : g_bad_ports
      $error("MEM_PORTS must lie between 1 and LANES");
   end

   logic [DEPTH*ADDR_W-1:0] e_addr_q;
   logic [DEPTH*2-1:0]      e_size_q;
   logic [DEPTH*DATA_W-1:0] e_data_q;
   logic [DEPTH*SEQ_W-1:0]  e_seq_q;
   logic [DEPTH-1:0]        e_wr_q, e_done_q;
   logic [IDX_W-1:0]        head_q, tail_q;
   logic [IDX_W:0]          cnt_q;
   logic                    alloc_ok, retire_ok;

   logic [LANES-1:0] rej, hfull, hpart, issue, starve;
   logic [IDX_W-1:0] hidx [LANES];
   logic [DATA_W-1:0] hdata [LANES];

   assign sq_full   = cnt_q >= (IDX_W+1)'(DEPTH - 1);
   assign alloc_idx = tail_q;
   assign alloc_ok  = alloc_valid && !sq_full;
   assign retire_ok = retire_valid && (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q   <= '0;
         tail_q   <= '0;
         cnt_q    <= '0;
         e_wr_q   <= '0;
         e_done_q <= '0;
      end else begin
         if (alloc_ok) begin
            tail_q                          <= tail_q + 1'b1;
            e_seq_q[tail_q*SEQ_W +: SEQ_W]  <= alloc_seq;
            e_wr_q[tail_q]                  <= 1'b0;
            e_done_q[tail_q]                <= 1'b0;
         end
         if (wr_valid) begin
            e_addr_q[wr_idx*ADDR_W +: ADDR_W] <= wr_addr;
            e_size_q[wr_idx*2 +: 2]           <= wr_size;
            e_data_q[wr_idx*DATA_W +: DATA_W] <= wr_data;
            e_wr_q[wr_idx]                    <= 1'b1;
         end
         if (done_valid) e_done_q[done_idx] <= 1'b1;
         if (retire_ok) head_q <= head_q + 1'b1;
         cnt_q <= cnt_q + (IDX_W+1)'(alloc_ok) - (IDX_W+1)'(retire_ok);
      end
   end

   // one search engine per lookup lane
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      stq_probe #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_probe (
         .head    (head_q),
         .win     (ld_sq_tail[l*IDX_W +: IDX_W]),
         .ld_addr (ld_addr[l*ADDR_W +: ADDR_W]),
         .ld_size (ld_size[l*2 +: 2]),
         .e_addr  (e_addr_q),
         .e_size  (e_size_q),
         .e_wr    (e_wr_q),
         .e_done  (e_done_q),
         .e_data  (e_data_q),
         .hit_full(hfull[l]),
         .hit_part(hpart[l]),
         .hit_idx (hidx[l]),
         .fwd_data(hdata[l])
      );
      assign rej[l] = ld_valid[l] && ld_uncache[l] && !(ld_at_head[l] && ld_commit_ok[l]);

      always_ff @(posedge clk) begin
         if (!rst_n) fwd_valid[l] <= 1'b0;
         else        fwd_valid[l] <= ld_valid[l] && !rej[l] && hfull[l];
         fwd_data[l*DATA_W +: DATA_W] <= hdata[l];
         fwd_lq_idx[l*LQ_W +: LQ_W]   <= ld_lq_idx[l*LQ_W +: LQ_W];
      end

      assign replay[l]                    = rej[l] || (ld_valid[l] && hpart[l]) || starve[l];
      assign fault[l]                     = rej[l];
      assign mem_rd_valid[l]              = issue[l];
      assign mem_rd_addr[l*ADDR_W +: ADDR_W] = ld_addr[l*ADDR_W +: ADDR_W];
      assign mem_rd_size[l*2 +: 2]        = ld_size[l*2 +: 2];
   end

   // per-cycle memory port budget, lowest lane first
   always_comb begin
      int used;
      used   = 0;
      issue  = '0;
      starve = '0;
      for (int l = 0; l < LANES; l++) begin
         if (ld_valid[l] && !rej[l] && !hfull[l] && !hpart[l]) begin
            if (used < MEM_PORTS) begin
               issue[l] = 1'b1;
               used     = used + 1;
            end else begin
               starve[l] = 1'b1;
            end
         end
      end
   end

   // oldest candidates this cycle for the stall and blocked records
   logic             sc_v, bc_v;
   logic [SEQ_W-1:0] sc_ld, sc_st, bc_seq;
   logic [LQ_W-1:0]  sc_lq;
   logic [SEQ_W-1:0] stall_ld_seq_q;

   always_comb begin
      sc_v = 1'b0; sc_ld = '0; sc_st = '0; sc_lq = '0;
      bc_v = 1'b0; bc_seq = '0;
      for (int l = 0; l < LANES; l++) begin
         if (ld_valid[l] && !rej[l] && hpart[l] &&
             (!sc_v || ld_seq[l*SEQ_W +: SEQ_W] < sc_ld)) begin
            sc_v  = 1'b1;
            sc_ld = ld_seq[l*SEQ_W +: SEQ_W];
            sc_st = e_seq_q[hidx[l]*SEQ_W +: SEQ_W];
            sc_lq = ld_lq_idx[l*LQ_W +: LQ_W];
         end
         if (issue[l] && !mem_rd_ready[l] &&
             (!bc_v || ld_seq[l*SEQ_W +: SEQ_W] < bc_seq)) begin
            bc_v   = 1'b1;
            bc_seq = ld_seq[l*SEQ_W +: SEQ_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stalled        <= 1'b0;
         stall_st_seq   <= '0;
         stall_lq_idx   <= '0;
         stall_ld_seq_q <= '0;
         blocked        <= 1'b0;
         blocked_seq    <= '0;
      end else begin
         if (done_valid && stalled && e_seq_q[done_idx*SEQ_W +: SEQ_W] == stall_st_seq)
            stalled <= 1'b0;
         if (sc_v && (!stalled || sc_ld < stall_ld_seq_q)) begin
            stalled        <= 1'b1;
            stall_st_seq   <= sc_st;
            stall_lq_idx   <= sc_lq;
            stall_ld_seq_q <= sc_ld;
         end
         if (blocked_clear) blocked <= 1'b0;
         if (bc_v && (!blocked || blocked_clear || bc_seq < blocked_seq)) begin
            blocked     <= 1'b1;
            blocked_seq <= bc_seq;
         end
      end
   end
endmodule

// File: rtl/stq_fwd_chk.sv
module stq_fwd_chk #(
   parameter int DEPTH     = 8,
   parameter int LANES     = 2,
   parameter int SEQ_W     = 16,
   parameter int MEM_PORTS = 1,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W:0]   cnt_q,
   input logic             sq_full,
   input logic             alloc_valid,
   input logic             retire_valid,
   input logic [LANES-1:0] ld_valid,
   input logic [LANES-1:0] fwd_valid,
   input logic [LANES-1:0] replay,
   input logic [LANES-1:0] fault,
   input logic [LANES-1:0] mem_rd_valid,
   input logic             blocked,
   input logic [SEQ_W-1:0] blocked_seq,
   input logic             blocked_clear
);
   assert_occupancy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= (IDX_W+1)'(DEPTH - 1));

   assert_full_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_full && alloc_valid && !retire_valid) |=> sq_full);

   assert_fwd_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid & ~$past(ld_valid)) == '0);

   assert_replay_no_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid & $past(replay & ld_valid)) == '0);

   assert_port_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mem_rd_valid) <= MEM_PORTS);

   assert_read_or_replay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid & replay) == '0);

   assert_blocked_oldest_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked && $past(blocked) && !$past(blocked_clear)) |-> blocked_seq <= $past(blocked_seq));

   assert_fault_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fault & mem_rd_valid) == '0);
endmodule

bind stq_fwd stq_fwd_chk #(.DEPTH(DEPTH), .LANES(LANES), .SEQ_W(SEQ_W), .MEM_PORTS(MEM_PORTS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cnt_q        (cnt_q),
   .sq_full      (sq_full),
   .alloc_valid  (alloc_valid),
   .retire_valid (retire_valid),
   .ld_valid     (ld_valid),
   .fwd_valid    (fwd_valid),
   .replay       (replay),
   .fault        (fault),
   .mem_rd_valid (mem_rd_valid),
   .blocked      (blocked),
   .blocked_seq  (blocked_seq),
   .blocked_clear(blocked_clear)
);

// File: tb/stq_fwd_tb.sv
`timescale 1ns/1ps
module stq_fwd_tb;
   localparam int D = 8, L = 2, AW = 16, DW = 64, SW = 16, LW = 4, IW = 3;

   logic clk = 0, rst_n = 0;
   always #2.5 clk = ~clk;

   logic alloc_valid = 0; logic [SW-1:0] alloc_seq = 0; logic [IW-1:0] alloc_idx; logic sq_full;
   logic wr_valid = 0; logic [IW-1:0] wr_idx = 0; logic [AW-1:0] wr_addr = 0;
   logic [1:0] wr_size = 0; logic [DW-1:0] wr_data = 0;
   logic done_valid = 0; logic [IW-1:0] done_idx = 0; logic retire_valid = 0;
   logic [L-1:0] ld_valid = 0, ld_uncache = 0, ld_at_head = 0, ld_commit_ok = 0;
   logic [L*AW-1:0] ld_addr = 0; logic [L*2-1:0] ld_size = 0; logic [L*IW-1:0] ld_sq_tail = 0;
   logic [L*SW-1:0] ld_seq = 0; logic [L*LW-1:0] ld_lq_idx = 0;
   logic [L-1:0] fwd_valid, replay, fault, mem_rd_valid; logic [L-1:0] mem_rd_ready = '1;
   logic [L*DW-1:0] fwd_data; logic [L*LW-1:0] fwd_lq_idx;
   logic [L*AW-1:0] mem_rd_addr; logic [L*2-1:0] mem_rd_size;
   logic stalled, blocked, blocked_clear = 0; logic [SW-1:0] stall_st_seq, blocked_seq;
   logic [LW-1:0] stall_lq_idx;

   stq_fwd u_dut (.*);

   int checks = 0, fails = 0; bit finished = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
   endtask

   // bench model of the queue
   logic [AW-1:0] m_addr [D]; logic [1:0] m_size [D]; logic [DW-1:0] m_data [D];
   bit m_wr [D]; bit m_done [D]; int m_head, m_tail, m_cnt;

   task automatic m_clear(); m_head = 0; m_tail = 0; m_cnt = 0;
      for (int i = 0; i < D; i++) begin m_wr[i] = 0; m_done[i] = 0; end
   endtask

   // kind: 0 none, 1 full cover, 2 partial pending
   task automatic model(input int a, input int sz, input int win, output int kind, output longint dat);
      int span, idx, la, lh, sa, se, off;
      kind = 0; dat = 0; span = (win - m_head) & (D-1);
      la = a; lh = a + (1 << sz);
      for (int k = 0; k < D; k++) begin
         idx = (m_head + k) & (D-1);
         sa = int'(m_addr[idx]); se = sa + (1 << m_size[idx]);
         if (k < span && m_wr[idx]) begin
            if (la >= sa && lh <= se) begin
               kind = 1; off = la & ((1 << m_size[idx]) - 1);
               dat = longint'(m_data[idx] >> (off*8));
               if (sz < 3) dat = dat & ((64'd1 << (8 << sz)) - 1);
            end else if (la < se && lh > sa && !m_done[idx]) kind = 2;
         end
      end
   endtask

   task automatic do_alloc(input int seq);
      @(negedge clk); alloc_valid = 1; alloc_seq = SW'(seq);
      @(posedge clk); #1 alloc_valid = 0;
      if (m_cnt < D-1) begin m_wr[m_tail] = 0; m_done[m_tail] = 0; m_tail = (m_tail+1)%D; m_cnt++; end
   endtask
   task automatic do_write(input int idx, input int a, input int sz, input longint dat);
      @(negedge clk); wr_valid = 1; wr_idx = IW'(idx); wr_addr = AW'(a); wr_size = 2'(sz); wr_data = dat;
      @(posedge clk); #1 wr_valid = 0;
      m_addr[idx] = AW'(a); m_size[idx] = 2'(sz); m_data[idx] = dat; m_wr[idx] = 1;
   endtask
   task automatic do_done(input int idx);
      @(negedge clk); done_valid = 1; done_idx = IW'(idx);
      @(posedge clk); #1 done_valid = 0; m_done[idx] = 1;
   endtask
   task automatic do_retire();
      @(negedge clk); retire_valid = 1;
      @(posedge clk); #1 retire_valid = 0;
      if (m_cnt > 0) begin m_head = (m_head+1)%D; m_cnt--; end
   endtask
   task automatic set_lane(input int l, input int a, input int sz, input int win, input int seq, input int lq);
      ld_valid[l] = 1; ld_addr[l*AW +: AW] = AW'(a); ld_size[l*2 +: 2] = 2'(sz);
      ld_sq_tail[l*IW +: IW] = IW'(win); ld_seq[l*SW +: SW] = SW'(seq); ld_lq_idx[l*LW +: LW] = LW'(lq);
   endtask
   task automatic finish_lookup(); @(posedge clk); #1 ld_valid = 0; ld_uncache = 0; mem_rd_ready = '1; @(negedge clk); endtask

   // single-lane lookup checked against the model; leaves the clock at the negedge after the edge
   task automatic probe(input string tag, input int a, input int sz, input int win, input int seq, input int lq);
      int kind; longint dat;
      model(a, sz, win, kind, dat);
      @(negedge clk); set_lane(0, a, sz, win, seq, lq); #1;
      chk(replay[0] == (kind == 2), {tag, " replay"}, replay[0], kind == 2);
      chk(mem_rd_valid[0] == (kind == 0), {tag, " mem read"}, mem_rd_valid[0], kind == 0);
      if (kind == 0) chk(mem_rd_addr[AW-1:0] == AW'(a), {tag, " read addr"}, mem_rd_addr[AW-1:0], a);
      finish_lookup();
      chk(fwd_valid[0] == (kind == 1), {tag, " fwd_valid"}, fwd_valid[0], kind == 1);
      if (kind == 1) begin
         chk(fwd_data[DW-1:0] == dat, {tag, " fwd data"}, fwd_data[DW-1:0], dat);
         chk(fwd_lq_idx[LW-1:0] == LW'(lq), {tag, " fwd lq idx"}, fwd_lq_idx[LW-1:0], lq);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         fails++; $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      m_clear();
      repeat (3) @(posedge clk); #1 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(sq_full == 0, "R1 reset full", sq_full, 0);
      chk(alloc_idx == 0, "R1 reset alloc idx", alloc_idx, 0);
      chk(stalled == 0 && blocked == 0, "R1 reset records", {stalled, blocked}, 0);
      chk(fwd_valid == 0 && mem_rd_valid == 0, "R1 reset outputs", {fwd_valid, mem_rd_valid}, 0);

      for (int i = 0; i < 7; i++) do_alloc(10 + i);
      @(negedge clk);
      chk(sq_full == 1, "R1 full at DEPTH-1", sq_full, 1);
      do_alloc(99); @(negedge clk);
      chk(alloc_idx == 7, "R1 alloc ignored when full", alloc_idx, 7);

      do_write(0, 'h100, 3, 64'h8877665544332211);
      do_write(1, 'h108, 2, 64'h00000000DDCCBBAA);
      do_write(2, 'h100, 1, 64'h000000000000F0E1);

      probe("R3 full cover shift", 'h102, 1, 3, 30, 1);
      probe("R4 youngest wins", 'h100, 0, 3, 31, 2);
      probe("R2 window excludes younger", 'h100, 0, 2, 32, 3);
      probe("R3 word from word store", 'h10A, 1, 3, 33, 4);
      probe("R2 unwritten slot skipped", 'h300, 2, 4, 34, 5);

      // R6 partial overlap with pending store
      probe("R6 partial pending", 'h100, 2, 3, 50, 5);
      chk(stalled == 1, "R6 stall set", stalled, 1);
      chk(stall_st_seq == 12, "R6 stall store seq", stall_st_seq, 12);
      chk(stall_lq_idx == 5, "R6 stall lq idx", stall_lq_idx, 5);
      probe("R6 older load", 'h100, 2, 3, 40, 3);
      chk(stall_lq_idx == 3, "R6 older load takes record", stall_lq_idx, 3);
      probe("R6 younger load", 'h100, 2, 3, 60, 7);
      chk(stall_lq_idx == 3, "R6 younger load ignored", stall_lq_idx, 7'd3);
      do_done(2); @(negedge clk);
      chk(stalled == 0, "R6 stall cleared by done", stalled, 0);
      probe("R5 done partial passed over", 'h100, 2, 3, 61, 8);

      // R8 memory reject
      @(negedge clk); set_lane(0, 'h300, 2, 4, 70, 1); mem_rd_ready[0] = 0; #1;
      chk(mem_rd_valid[0] == 1, "R8 read issued", mem_rd_valid[0], 1);
      finish_lookup();
      chk(blocked == 1 && blocked_seq == 70, "R8 blocked record", blocked_seq, 70);
      @(negedge clk); set_lane(0, 'h300, 2, 4, 80, 1); mem_rd_ready[0] = 0; finish_lookup();
      chk(blocked_seq == 70, "R8 younger keeps record", blocked_seq, 70);
      @(negedge clk); set_lane(0, 'h300, 2, 4, 65, 1); mem_rd_ready[0] = 0; finish_lookup();
      chk(blocked_seq == 65, "R8 older replaces", blocked_seq, 65);
      @(negedge clk); blocked_clear = 1; @(posedge clk); #1 blocked_clear = 0; @(negedge clk);
      chk(blocked == 0, "R8 clear", blocked, 0);

      // R9 uncacheable
      @(negedge clk); set_lane(0, 'h300, 2, 4, 90, 2); ld_uncache[0] = 1; ld_at_head[0] = 0; ld_commit_ok[0] = 1; #1;
      chk(fault[0] == 1 && replay[0] == 1, "R9 fault and replay", {fault[0], replay[0]}, 3);
      chk(mem_rd_valid[0] == 0, "R9 no read", mem_rd_valid[0], 0);
      ld_at_head[0] = 1; #1;
      chk(fault[0] == 0 && mem_rd_valid[0] == 1, "R9 head and ready proceeds", {fault[0], mem_rd_valid[0]}, 1);
      finish_lookup();

      // R7 port budget across lanes
      @(negedge clk); set_lane(0, 'h300, 2, 4, 91, 1); set_lane(1, 'h400, 2, 4, 92, 2); #1;
      chk(mem_rd_valid == 2'b01, "R7 lane0 gets port", mem_rd_valid, 1);
      chk(replay == 2'b10, "R7 lane1 starved replays", replay, 2);
      finish_lookup();

      // random mix
      @(negedge clk); rst_n = 0; @(posedge clk); #1 rst_n = 1; m_clear();
      for (int it = 0; it < 400; it++) begin
         int op, sz, a, idx, win;
         op = $urandom % 5;
         if (op == 0 && m_cnt < D-1) do_alloc(100 + it);
         else if (op == 1 && m_cnt > 0) begin
            sz = $urandom % 4; a = 'h100 + (($urandom % 32) & ~((1 << sz) - 1));
            idx = (m_head + ($urandom % m_cnt)) % D;
            do_write(idx, a, sz, {$urandom, $urandom});
         end else if (op == 2 && m_cnt > 0) do_done((m_head + ($urandom % m_cnt)) % D);
         else if (op == 3 && m_cnt > 2) do_retire();
         else begin
            sz = $urandom % 4; a = 'h100 + (($urandom % 32) & ~((1 << sz) - 1));
            win = (m_head + ($urandom % (m_cnt + 1))) % D;
            probe("R2 R3 R4 R5 R6 random", a, sz, win, 1000 + it, it % 16);
         end
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule